// File: doc/BRIEF.md
# Prioritized External Interrupt Dispatcher

This block sits beside a processor core and decides which pending interruption the core takes next, then performs the status-word swap for it. It tracks three external sources: a small last-in-first-out stack of queued external events, each with a 16-bit code and a 32-bit parameter; a clock-comparator pending flag; and a CPU-timer pending flag. It also accepts one-cycle requests for a program exception and for a supervisor call. The current status word (a 64-bit mask and a 64-bit address) and the condition code are held inside the block.

When an interruption is chosen, the block uses a 64-bit memory port to store an information word, the old mask and the old address into fixed low-memory slots of that interruption class, one access per cycle. It then reads the new mask and new address from the same area and makes them the current status word. A new status word with its wait bit set leaves the core halted until the next interruption begins. The hard interrupt request output tells the core whether any external source is still pending.

Top module: `irq_dispatch`

## Requirements
- R1: After a synchronous active-low reset the status mask, status address and condition code are zero, busy, halted, fatal and irq_hard are low, and no memory access is issued.
- R2: Class priority is program exception, then supervisor call, then external. External sources are taken only when bit 56 of the current mask is set and no program or call request is present in that idle cycle. Pending external sources are kept while that bit is clear.
- R3: Among external sources the stacked events come first, then the clock comparator (code 0x1004, parameter 0), then the CPU timer (code 0x1005, parameter 0). Taking a timer clears only that timer's pending flag.
- R4: Up to QDEPTH events are stacked and delivered newest first. A push that finds the stack full, after any pop in the same cycle, is discarded and sets fatal, which stays set until reset.
- R5: A swap starts in the cycle after the start decision and issues one access per cycle: write info at base+0x10, write old mask at base+0x00, write old address at base+0x08, read new mask at base+0x18, then read new address at base+0x20. Base is 0x000 for external, 0x040 for supervisor call and 0x080 for program exception, plus LOW_BASE. Read data arrives one cycle after its request. busy is high for six cycles and the new status word is visible in the cycle after the last one.
- R6: The stored old mask equals the current mask with bits 14:13 replaced by cc_in, sampled in the start cycle. After a load, cc_out equals bits 14:13 of the new mask.
- R7: For an external interruption the info word holds the code in bits 15:0, cpu_num ORed with 0x0D00 in bits 31:16, and the parameter in bits 63:32. The stored old address is the current address.
- R8: For a supervisor call the stored old address is the current address plus svc_len. The info word holds svc_code in bits 15:0, svc_len zero-extended in bits 31:16, and zeros above.
- R9: For a program exception the length in halfwords comes from pgm_op_hi: 00 gives 1, 01 and 10 give 2, 11 gives 3. The info word holds pgm_code in bits 15:0 and the stored length in bits 31:16. Mode 1 stores the length and advances the old address by twice it. Mode 2 stores twice the length and advances by that amount. Modes 0 and 3 store the length and do not advance.
- R10: Loading a status word with bit 49 set, either by a swap or by a direct write, raises halted. halted falls in the cycle after any interruption start.
- R11: irq_hard is high exactly while the stack is non-empty or either timer flag is pending, whatever the mask.
- R12: psw_wr is accepted only while busy is low and takes precedence over starting an interruption in that cycle. A program or call request in that cycle, or while busy, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_num | input | 16 | Processor number placed in the external info word |
| cc_in | input | 2 | Live condition code merged into the saved mask |
| psw_wr | input | 1 | Direct write of the status word |
| psw_wr_mask | input | 64 | Mask for a direct write |
| psw_wr_addr | input | 64 | Address for a direct write |
| ext_push | input | 1 | Push one external event onto the stack |
| ext_code | input | 16 | Code of the pushed event |
| ext_param | input | 32 | Parameter of the pushed event |
| clkcmp_set | input | 1 | Sets the clock-comparator pending flag |
| cputmr_set | input | 1 | Sets the CPU-timer pending flag |
| pgm_req | input | 1 | Program-exception request pulse |
| pgm_code | input | 16 | Program-exception code |
| pgm_op_hi | input | 2 | Top two bits of the faulting opcode |
| pgm_len_mode | input | 2 | Length-handling mode for the program exception |
| svc_req | input | 1 | Supervisor-call request pulse |
| svc_code | input | 16 | Supervisor-call code |
| svc_len | input | 4 | Length in bytes of the call instruction |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the 64-bit access |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after the request |
| psw_mask | output | 64 | Current status mask |
| psw_addr | output | 64 | Current status address |
| cc_out | output | 2 | Condition code taken from the last loaded mask |
| halted | output | 1 | Processor halted by a wait-state status word |
| busy | output | 1 | Swap sequence in progress |
| irq_hard | output | 1 | Some external source is pending |
| fatal | output | 1 | Sticky stack-overflow indication |

## Verification
The in-line assertions check on every cycle that the stack count stays within its depth, that fatal never clears, that delivering a stacked event lowers the count by one, that the access sequence advances in its fixed order, that a start is only presented to an idle sequencer and raises busy, and that halted rises only on a status load. Which event is delivered, the order of stack and timer sources, the exact slot addresses, and the contents of the info word, saved mask and saved address for each class and length mode are shown only by the bench scenarios. These scenarios cover overflow, masking, priority collisions, dropped requests and wake from wait, with a cycle-by-cycle reference model comparing every output.

// File: rtl/irqd_pkg.sv
// Shared constants and types for the interrupt dispatcher.
// Assumes a 64-bit status word and a 64-bit memory data path.
package irqd_pkg;

    localparam int WORD_W       = 64;
    localparam int EXT_EN_BIT   = 56;   // mask bit enabling external sources
    localparam int WAIT_BIT     = 49;   // mask bit requesting the halted state
    localparam int CC_LO        = 13;   // condition code sits in bits CC_LO+1:CC_LO

    localparam logic [15:0] CODE_CLKCMP  = 16'h1004;
    localparam logic [15:0] CODE_CPUTMR  = 16'h1005;
    localparam logic [15:0] CPU_ADDR_TAG = 16'h0D00;

    // byte offsets inside each class area
    localparam logic [7:0] SLOT_OMASK = 8'h00;
    localparam logic [7:0] SLOT_OADDR = 8'h08;
    localparam logic [7:0] SLOT_INFO  = 8'h10;
    localparam logic [7:0] SLOT_NMASK = 8'h18;
    localparam logic [7:0] SLOT_NADDR = 8'h20;

    // program-exception length modes
    localparam logic [1:0] LEN_PLAIN = 2'd0;
    localparam logic [1:0] LEN_ADV   = 2'd1;
    localparam logic [1:0] LEN_DBL   = 2'd2;

    typedef enum logic [1:0] {
        CLS_EXT = 2'd0,
        CLS_SVC = 2'd1,
        CLS_PGM = 2'd2
    } irq_cls_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_INFO, SQ_OMASK, SQ_OADDR, SQ_RMASK, SQ_RADDR, SQ_LOAD
    } sq_state_e;

    typedef struct packed {
        logic [15:0] code;
        logic [31:0] param;
    } ext_evt_t;

    // base byte offset of each class area inside the save region
    function automatic logic [7:0] class_base(irq_cls_e c);
        case (c)
            CLS_SVC: return 8'h40;
            CLS_PGM: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/irqd_len_calc.sv
// Program-exception length calculator.
// Derives the instruction length in halfwords from the top two opcode bits
// and applies the selected length mode. Purely combinational.
module irqd_len_calc
    import irqd_pkg::*;
(
    input  logic [1:0]  op_hi,
    input  logic [1:0]  mode,
    output logic [15:0] len_code,
    output logic [7:0]  adv_bytes
);

    logic [7:0] hw;

    // halfword count from the opcode class
    always_comb begin
        case (op_hi)
            2'b00:   hw = 8'd1;
            2'b11:   hw = 8'd3;
            default: hw = 8'd2;
        endcase
    end

    // stored length and address advance per mode
    always_comb begin
        case (mode)
            LEN_ADV: begin
                len_code  = {8'h00, hw};
                adv_bytes = hw << 1;
            end
            LEN_DBL: begin
                len_code  = {8'h00, hw << 1};
                adv_bytes = hw << 1;
            end
            default: begin
                len_code  = {8'h00, hw};
                adv_bytes = 8'd0;
            end
        endcase
    end

    // R9: the advance never exceeds three halfwords
    always_comb begin
        a_r9_adv_bound: assert (adv_bytes <= 8'd6);
    end

endmodule

// File: rtl/irqd_src_arb.sv
// External source store and arbiter.
// Holds the last-in-first-out event stack and the two timer pending flags,
// presents the highest-priority external source, and retires it on take.
// Assumes take is raised only when avail is high.
module irqd_src_arb
    import irqd_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  ext_evt_t    push_evt,
    input  logic        tod_set,
    input  logic        cpt_set,
    input  logic        take,
    output logic        avail,
    output logic [15:0] sel_code,
    output logic [31:0] sel_param,
    output logic        pending_any,
    output logic        overflow
);

    localparam int CW = $clog2(QDEPTH + 1);
    localparam int IW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

    ext_evt_t       stk [QDEPTH];
    logic [CW-1:0]  cnt;
    logic           tod_q, cpt_q, fatal_q;
    logic           have_stk, pop, tod_clr, cpt_clr, full;
    logic [CW-1:0]  cnt_after_pop;
    ext_evt_t       top_evt;

    // source selection and retirement decode
    always_comb begin
        have_stk      = (cnt != '0);
        top_evt       = stk[IW'(cnt - CW'(1))];
        pop           = take & have_stk;
        tod_clr       = take & ~have_stk & tod_q;
        cpt_clr       = take & ~have_stk & ~tod_q & cpt_q;
        cnt_after_pop = cnt - CW'(pop);
        full          = (cnt_after_pop == CW'(QDEPTH));
        avail         = have_stk | tod_q | cpt_q;
        pending_any   = avail;
        if (have_stk) begin
            sel_code  = top_evt.code;
            sel_param = top_evt.param;
        end else if (tod_q) begin
            sel_code  = CODE_CLKCMP;
            sel_param = '0;
        end else begin
            sel_code  = CODE_CPUTMR;
            sel_param = '0;
        end
    end

    // stack count, timer flags and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            tod_q   <= 1'b0;
            cpt_q   <= 1'b0;
            fatal_q <= 1'b0;
        end else begin
            cnt     <= (push && !full) ? cnt_after_pop + CW'(1) : cnt_after_pop;
            tod_q   <= (tod_q & ~tod_clr) | tod_set;
            cpt_q   <= (cpt_q & ~cpt_clr) | cpt_set;
            fatal_q <= fatal_q | (push & full);
        end
    end

    // stack storage write, no reset needed
    always_ff @(posedge clk) begin
        if (rst_n && push && !full)
            stk[IW'(cnt_after_pop)] <= push_evt;
    end

    assign overflow = fatal_q;

    // R4: count never exceeds the stack depth
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(QDEPTH));

    // R4: overflow indication is sticky
    a_r4_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_q |=> fatal_q);

    // R4: taking a stacked event without a push lowers the count by one
    a_r4_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
        (take && have_stk && !push) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/irqd_swap_seq.sv
// Status-word swap sequencer.
// Captures the words to save on start, then issues three writes and two
// reads to the class area, one per cycle, and presents the new status word
// in its last cycle. Assumes read data returns one cycle after the request.
module irqd_swap_seq
    import irqd_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int unsigned LOW_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  irq_cls_e          cls,
    input  logic [WORD_W-1:0] info,
    input  logic [WORD_W-1:0] omask,
    input  logic [WORD_W-1:0] oaddr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic              load_now,
    output logic [WORD_W-1:0] new_mask,
    output logic [WORD_W-1:0] new_addr
);

    sq_state_e         st;
    irq_cls_e          cls_q;
    logic [WORD_W-1:0] info_q, omask_q, oaddr_q, nmask_q;
    logic [7:0]        slot;

    // sequence state and captured words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            cls_q   <= CLS_EXT;
            info_q  <= '0;
            omask_q <= '0;
            oaddr_q <= '0;
            nmask_q <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    st      <= SQ_INFO;
                    cls_q   <= cls;
                    info_q  <= info;
                    omask_q <= omask;
                    oaddr_q <= oaddr;
                end
                SQ_INFO:  st <= SQ_OMASK;
                SQ_OMASK: st <= SQ_OADDR;
                SQ_OADDR: st <= SQ_RMASK;
                SQ_RMASK: st <= SQ_RADDR;
                SQ_RADDR: begin
                    st      <= SQ_LOAD;
                    nmask_q <= mem_rdata;
                end
                default:  st <= SQ_IDLE;
            endcase
        end
    end

    // memory port drive for the current step
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (st)
            SQ_INFO:  begin slot = SLOT_INFO;  mem_we = 1'b1; mem_wdata = info_q;  end
            SQ_OMASK: begin slot = SLOT_OMASK; mem_we = 1'b1; mem_wdata = omask_q; end
            SQ_OADDR: begin slot = SLOT_OADDR; mem_we = 1'b1; mem_wdata = oaddr_q; end
            SQ_RMASK: slot = SLOT_NMASK;
            SQ_RADDR: slot = SLOT_NADDR;
            default:  begin slot = 8'h00; mem_req = 1'b0; end
        endcase
        mem_addr = AW'(LOW_BASE) + AW'(class_base(cls_q)) + AW'(slot);
    end

    assign busy     = (st != SQ_IDLE);
    assign load_now = (st == SQ_LOAD);
    assign new_mask = nmask_q;
    assign new_addr = mem_rdata;

    // R5: the info write is always followed by the old-mask write
    a_r5_seq_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_INFO) |=> (st == SQ_OMASK));

    // R12: the controller presents a start only to an idle sequencer
    a_r12_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == SQ_IDLE));

endmodule

// File: rtl/irq_dispatch.sv
// Prioritized interrupt dispatcher, top level.
// Holds the current status word, chooses among program, call and external
// interruptions, builds the words to save, and loads the new status word
// at the end of the swap. Assumes request pulses last one cycle.
module irq_dispatch
    import irqd_pkg::*;
#(
    parameter int          QDEPTH   = 4,
    parameter int          AW       = 16,
    parameter int unsigned LOW_BASE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   cpu_num,
    input  logic [1:0]    cc_in,
    input  logic          psw_wr,
    input  logic [63:0]   psw_wr_mask,
    input  logic [63:0]   psw_wr_addr,
    input  logic          ext_push,
    input  logic [15:0]   ext_code,
    input  logic [31:0]   ext_param,
    input  logic          clkcmp_set,
    input  logic          cputmr_set,
    input  logic          pgm_req,
    input  logic [15:0]   pgm_code,
    input  logic [1:0]    pgm_op_hi,
    input  logic [1:0]    pgm_len_mode,
    input  logic          svc_req,
    input  logic [15:0]   svc_code,
    input  logic [3:0]    svc_len,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic [63:0]   mem_rdata,
    output logic [63:0]   psw_mask,
    output logic [63:0]   psw_addr,
    output logic [1:0]    cc_out,
    output logic          halted,
    output logic          busy,
    output logic          irq_hard,
    output logic          fatal
);

    logic [63:0] mask_q, addr_q;
    logic [1:0]  cc_q;
    logic        halted_q;

    logic        ext_avail, go_pgm, go_svc, go_ext, start, load_now, may_start;
    logic [15:0] ext_sel_code, pgm_len;
    logic [31:0] ext_sel_param;
    logic [7:0]  pgm_adv;
    irq_cls_e    cls;
    logic [63:0] info, omask, oaddr, new_mask, new_addr;
    ext_evt_t    push_evt;

    assign push_evt = '{code: ext_code, param: ext_param};

    irqd_src_arb #(.QDEPTH(QDEPTH)) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (ext_push),
        .push_evt    (push_evt),
        .tod_set     (clkcmp_set),
        .cpt_set     (cputmr_set),
        .take        (go_ext),
        .avail       (ext_avail),
        .sel_code    (ext_sel_code),
        .sel_param   (ext_sel_param),
        .pending_any (irq_hard),
        .overflow    (fatal)
    );

    irqd_len_calc u_len (
        .op_hi     (pgm_op_hi),
        .mode      (pgm_len_mode),
        .len_code  (pgm_len),
        .adv_bytes (pgm_adv)
    );

    irqd_swap_seq #(.AW(AW), .LOW_BASE(LOW_BASE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cls       (cls),
        .info      (info),
        .omask     (omask),
        .oaddr     (oaddr),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .load_now  (load_now),
        .new_mask  (new_mask),
        .new_addr  (new_addr)
    );

    // class priority: program, then call, then enabled external
    always_comb begin
        may_start = ~busy & ~psw_wr;
        go_pgm    = may_start & pgm_req;
        go_svc    = may_start & ~pgm_req & svc_req;
        go_ext    = may_start & ~pgm_req & ~svc_req & mask_q[EXT_EN_BIT] & ext_avail;
        start     = go_pgm | go_svc | go_ext;
    end

    // words to save for the chosen class
    always_comb begin
        omask = mask_q;
        omask[CC_LO+1:CC_LO] = cc_in;
        if (go_pgm) begin
            cls   = CLS_PGM;
            info  = {32'h0, pgm_len, pgm_code};
            oaddr = addr_q + 64'(pgm_adv);
        end else if (go_svc) begin
            cls   = CLS_SVC;
            info  = {32'h0, 12'h0, svc_len, svc_code};
            oaddr = addr_q + 64'(svc_len);
        end else begin
            cls   = CLS_EXT;
            info  = {ext_sel_param, cpu_num | CPU_ADDR_TAG, ext_sel_code};
            oaddr = addr_q;
        end
    end

    // current status word, condition code and halted state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            addr_q   <= '0;
            cc_q     <= '0;
            halted_q <= 1'b0;
        end else if (psw_wr && !busy) begin
            mask_q   <= psw_wr_mask;
            addr_q   <= psw_wr_addr;
            cc_q     <= psw_wr_mask[CC_LO+1:CC_LO];
            halted_q <= psw_wr_mask[WAIT_BIT];
        end else if (start) begin
            halted_q <= 1'b0;
        end else if (load_now) begin
            mask_q   <= new_mask;
            addr_q   <= new_addr;
            cc_q     <= new_mask[CC_LO+1:CC_LO];
            halted_q <= new_mask[WAIT_BIT];
        end
    end

    assign psw_mask = mask_q;
    assign psw_addr = addr_q;
    assign cc_out   = cc_q;
    assign halted   = halted_q;

    // R5: a start always makes the sequencer busy next cycle
    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R10: halted rises only on a status-word load
    a_r10_halt_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_q) |-> $past(load_now || (psw_wr && !busy)));

    // R10: any interruption start clears halted
    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !halted_q);

endmodule

// File: tb/irq_dispatch_tb.sv
// Bench for irq_dispatch: behavioural reference model compared every cycle.
module irq_dispatch_tb;
    import irqd_pkg::*;

    localparam int QD = 4;
    localparam int AW = 16;
    localparam logic [63:0] M_EXT  = 64'h0100_0000_0000_0000; // bit 56
    localparam logic [63:0] M_WAIT = 64'h0002_0000_0000_0000; // bit 49

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [15:0]   cpu_num;
    logic [1:0]    cc_in;
    logic          psw_wr;
    logic [63:0]   psw_wr_mask, psw_wr_addr;
    logic          ext_push;
    logic [15:0]   ext_code;
    logic [31:0]   ext_param;
    logic          clkcmp_set, cputmr_set;
    logic          pgm_req;
    logic [15:0]   pgm_code;
    logic [1:0]    pgm_op_hi, pgm_len_mode;
    logic          svc_req;
    logic [15:0]   svc_code;
    logic [3:0]    svc_len;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata, mem_rdata;
    logic [63:0]   psw_mask, psw_addr;
    logic [1:0]    cc_out;
    logic          halted, busy, irq_hard, fatal;

    irq_dispatch #(.QDEPTH(QD), .AW(AW), .LOW_BASE(0)) u_dut (.*);

    // bench memory: 32 words covering the three class areas
    logic [63:0] mem [0:31];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:3]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:3]];
        end
    end

    int    n_cmp = 0, n_bad = 0;
    string tag = "R1";

    // reference model state
    int          ph;
    int          m_cls;
    logic [63:0] m_info, m_omask, m_oaddr, m_mask, m_addr;
    logic [1:0]  m_cc;
    logic        m_halt, m_tod, m_cpt, m_fatal, m_seen;
    logic [47:0] rq [$];

    function automatic logic [7:0] base_of(int c);
        return (c == 1) ? 8'h40 : (c == 2) ? 8'h80 : 8'h00;
    endfunction

    // reference model step on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_cls = 0; m_mask = '0; m_addr = '0; m_cc = '0;
            m_halt = 0; m_tod = 0; m_cpt = 0; m_fatal = 0; rq.delete();
            m_info = '0; m_omask = '0; m_oaddr = '0;
        end else begin
            if (ph == 0) begin
                bit st;
                st = 0;
                if (psw_wr) begin
                    m_mask = psw_wr_mask; m_addr = psw_wr_addr;
                    m_cc = psw_wr_mask[14:13]; m_halt = psw_wr_mask[49];
                end else if (pgm_req) begin
                    int hw, ln, adv;
                    hw = (pgm_op_hi == 2'b00) ? 1 : (pgm_op_hi == 2'b11) ? 3 : 2;
                    ln = hw; adv = 0;
                    if (pgm_len_mode == 2'd1) adv = 2 * hw;
                    if (pgm_len_mode == 2'd2) begin ln = 2 * hw; adv = ln; end
                    m_cls = 2; m_info = {32'h0, ln[15:0], pgm_code};
                    m_oaddr = m_addr + 64'(adv); st = 1;
                end else if (svc_req) begin
                    m_cls = 1; m_info = {32'h0, 12'h0, svc_len, svc_code};
                    m_oaddr = m_addr + 64'(svc_len); st = 1;
                end else if (m_mask[56] && (rq.size() > 0 || m_tod || m_cpt)) begin
                    logic [47:0] e;
                    m_cls = 0; m_oaddr = m_addr; st = 1;
                    if (rq.size() > 0) begin
                        e = rq.pop_back();
                        m_info = {e[31:0], cpu_num | 16'h0D00, e[47:32]};
                    end else if (m_tod) begin
                        m_tod = 0; m_info = {32'h0, cpu_num | 16'h0D00, 16'h1004};
                    end else begin
                        m_cpt = 0; m_info = {32'h0, cpu_num | 16'h0D00, 16'h1005};
                    end
                end
                if (st) begin
                    m_omask = m_mask; m_omask[14:13] = cc_in;
                    m_halt = 0; ph = 1;
                end
            end else if (ph == 6) begin
                m_mask = mem[(base_of(m_cls) + 8'h18) >> 3];
                m_addr = mem[(base_of(m_cls) + 8'h20) >> 3];
                m_cc = m_mask[14:13]; m_halt = m_mask[49]; ph = 0;
            end else begin
                ph = ph + 1;
            end
            if (ext_push) begin
                if (rq.size() == QD) m_fatal = 1;
                else rq.push_back({ext_code, ext_param});
            end
            if (clkcmp_set) m_tod = 1;
            if (cputmr_set) m_cpt = 1;
        end
        m_seen = 1;
    end

    task automatic chk(string sig, string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s actual=%h expected=%h at %0t", req, tag, sig, act, exp, $time);
        end
    endtask

    // compare every output against the model away from the edge
    always @(negedge clk) begin
        if (m_seen) begin
            logic [7:0] slot;
            logic [63:0] wd;
            slot = 8'h00; wd = '0;
            case (ph)
                1: begin slot = 8'h10; wd = m_info;  end
                2: begin slot = 8'h00; wd = m_omask; end
                3: begin slot = 8'h08; wd = m_oaddr; end
                4: slot = 8'h18;
                5: slot = 8'h20;
                default: slot = 8'h00;
            endcase
            chk("busy",     "R5",  64'(busy),    64'(ph != 0));
            chk("mem_req",  "R5",  64'(mem_req), 64'(ph >= 1 && ph <= 5));
            if (ph >= 1 && ph <= 5) begin
                chk("mem_we",   "R5", 64'(mem_we),   64'(ph <= 3));
                chk("mem_addr", "R5", 64'(mem_addr), 64'(base_of(m_cls) + slot));
                if (ph <= 3) chk("mem_wdata", "R7", mem_wdata, wd);
            end
            chk("psw_mask", "R6",  psw_mask, m_mask);
            chk("psw_addr", "R8",  psw_addr, m_addr);
            chk("cc_out",   "R6",  64'(cc_out),   64'(m_cc));
            chk("halted",   "R10", 64'(halted),   64'(m_halt));
            chk("irq_hard", "R11", 64'(irq_hard), 64'(rq.size() > 0 || m_tod || m_cpt));
            chk("fatal",    "R4",  64'(fatal),    64'(m_fatal));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(logic [15:0] c, logic [31:0] p);
        ext_push = 1; ext_code = c; ext_param = p;
        @(negedge clk);
        ext_push = 0;
    endtask

    task automatic wr_psw(logic [63:0] m, logic [63:0] a);
        psw_wr = 1; psw_wr_mask = m; psw_wr_addr = a;
        @(negedge clk);
        psw_wr = 0;
    endtask

    task automatic pgm(logic [15:0] c, logic [1:0] op, logic [1:0] md);
        pgm_req = 1; pgm_code = c; pgm_op_hi = op; pgm_len_mode = md;
        @(negedge clk);
        pgm_req = 0;
    endtask

    task automatic svc(logic [15:0] c, logic [3:0] l);
        svc_req = 1; svc_code = c; svc_len = l;
        @(negedge clk);
        svc_req = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        m_seen = 0;
        rst_n = 0; cpu_num = 16'h0007; cc_in = 2'b00;
        psw_wr = 0; psw_wr_mask = '0; psw_wr_addr = '0;
        ext_push = 0; ext_code = '0; ext_param = '0;
        clkcmp_set = 0; cputmr_set = 0;
        pgm_req = 0; pgm_code = '0; pgm_op_hi = '0; pgm_len_mode = '0;
        svc_req = 0; svc_code = '0; svc_len = '0;
        mem_rdata = '0;
        for (int i = 0; i < 32; i++) mem[i] = '0;
        mem[3]  = M_EXT | 64'h4000;          // external new mask, cc 10
        mem[4]  = 64'h1000;
        mem[11] = M_EXT | 64'h2000;          // call new mask, cc 01
        mem[12] = 64'h2000;
        mem[19] = 64'h6000;                  // program new mask, cc 11, external off
        mem[20] = 64'h3000;

        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R7 R11 R2: events held while masked, then delivered newest first (R4)
        tag = "R7";
        push(16'h0101, 32'hAAAA_0001);
        push(16'h0202, 32'hBBBB_0002);
        push(16'h0303, 32'hCCCC_0003);
        push(16'h0404, 32'hDDDD_0004);
        idle(4);
        tag = "R4";
        cc_in = 2'b01;
        wr_psw(M_EXT, 64'h500);
        idle(32);

        // R3: stacked event before clock comparator before CPU timer
        tag = "R3";
        cc_in = 2'b10;
        clkcmp_set = 1; cputmr_set = 1; ext_push = 1; ext_code = 16'h0777; ext_param = 32'h1234_5678;
        @(negedge clk);
        clkcmp_set = 0; cputmr_set = 0; ext_push = 0;
        idle(2);
        tag = "R12";
        wr_psw(64'h0, 64'hDEAD);             // dropped while busy
        idle(25);

        // R8: call taken ahead of a simultaneous clock comparator (R2)
        tag = "R8";
        cc_in = 2'b11;
        clkcmp_set = 1;
        svc(16'h0033, 4'd4);
        clkcmp_set = 0;
        idle(2);
        tag = "R12";
        pgm(16'h00EE, 2'b01, 2'd1);          // dropped while busy
        idle(20);

        // R9: program length modes; R2 program beats call and masks timer
        tag = "R9";
        cc_in = 2'b00;
        cputmr_set = 1; svc_req = 1; svc_code = 16'h0044; svc_len = 4'd2;
        pgm(16'h0010, 2'b00, 2'd0);
        cputmr_set = 0; svc_req = 0;
        idle(10);
        for (int md = 1; md < 4; md++) begin
            cc_in = md[1:0];
            pgm(16'h0010 + 16'(md), md[1:0], md[1:0]);
            idle(10);
        end
        pgm(16'h0019, 2'b11, 2'd2);
        idle(10);

        // R10: wait-state load halts, next interruption wakes
        tag = "R10";
        mem[19] = M_WAIT;
        pgm(16'h0020, 2'b10, 2'd0);
        idle(12);
        tag = "R12";
        svc_req = 1; svc_code = 16'h0055; svc_len = 4'd6;
        wr_psw(64'h0, 64'h700);              // write wins, call dropped
        svc_req = 0;
        idle(3);
        tag = "R10";
        svc(16'h0056, 4'd2);
        idle(20);

        // R4: overflow of the stack sets fatal, then drain
        tag = "R4";
        wr_psw(64'h0, 64'h800);
        for (int k = 0; k < 5; k++) push(16'h0900 + 16'(k), 32'(k));
        idle(3);
        wr_psw(M_EXT, 64'h900);
        idle(36);

        finish_run();
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog [%s] actual=running expected=done", tag);
        finish_run();
    end

endmodule